// File: doc/BRIEF.md
# Least-Recently-Executed Thread Selector

This block picks, on every clock, which of the threads of a fine-grained multithreaded pipeline issues next. It keeps an ordered list of thread numbers from the thread that has gone longest without issuing to the one that issued last. Each cycle it grants the oldest thread that is currently able to go. The chosen thread then moves to the newest end of the list.

A thread is held back in two cases. The first is while it waits on a long operation such as a branch, a multiply, a divide or an unspeculated load. The second is while the pipe stalls it for a cache miss, a trap or a resource conflict. A thread that has issued a load presumed to hit stays selectable. It only loses to every thread that has no such load outstanding. Stall, wait and load flags are sampled at the clock edge and act on the following cycle. The ready flag acts in the same cycle.

The output is a one-hot grant and a valid bit. Issue, rollback and fetch are handled by the surrounding pipeline.

Top module: `thread_pick`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `issue_valid` is 0 and `issue_sel` is all zeros. Reset leaves the recency list ordered from thread 0 as oldest to thread 3 as newest.
- R2: A thread whose `thr_ready` bit is 0 is not granted in that cycle. A thread whose `thr_stall` or `thr_longwait` bit is 1 at a clock edge is not granted in the cycle after that edge.
- R3: Among eligible threads with no speculative load flagged at the previous edge, the grant goes to the one nearest the oldest end of the recency list.
- R4: A thread whose `thr_specload` bit was 1 at the previous edge is granted only when no eligible thread lacks that flag. Among such threads, recency order decides.
- R5: The granted thread becomes the newest entry of the list at the next edge, and all other threads keep their relative order. With every thread always eligible, the grants cycle 0,1,2,3,0 after reset.
- R6: In a cycle with no grant the recency list does not change.
- R7: `issue_sel` has at most one bit set, and `issue_valid` is 1 exactly when a bit is set.
- R8: When at least one thread is eligible, a grant is made in that cycle.
- R9: Being blocked or unblocked never moves a thread in the recency list. A thread freed after waiting keeps the position it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | NTHR | Per-thread: an instruction is ready to issue this cycle |
| thr_stall | input | NTHR | Per-thread: pipeline stall (miss, trap, conflict) |
| thr_longwait | input | NTHR | Per-thread: waiting on a long-latency operation |
| thr_specload | input | NTHR | Per-thread: a load presumed to hit is outstanding |
| issue_sel | output | NTHR | One-hot grant of the thread issuing this cycle |
| issue_valid | output | 1 | A thread is granted this cycle |

## Verification
The embedded properties check on every cycle that the grant is one-hot and agrees with the valid bit. They also check that no thread is granted while unready or one cycle after a stall or wait flag, and that a flagged speculative-load thread never wins over a clean eligible one. On the list itself they check that it stays a permutation, that the last winner lands at the newest slot, and that it is frozen in idle cycles. Which thread wins among several candidates depends on the history of grants, and only the bench can show it. The bench does this with a queue model compared every cycle, across directed scenarios (reset order, rotation, a blocked thread keeping its place, idle stretches) and a long run of random stimulus.

// File: rtl/thread_pick.sv
module thread_pick #(
  parameter int NTHR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] thr_stall,
  input  logic [NTHR-1:0] thr_longwait,
  input  logic [NTHR-1:0] thr_specload,
  output logic [NTHR-1:0] issue_sel,
  output logic            issue_valid
);
  localparam int IDW = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [NTHR-1:0] blk_q, spec_q, elig;
  logic [IDW-1:0]  ord_q [NTHR];
  logic [IDW-1:0]  pos_n, pos_s, pick_pos, pick_id;
  logic            hit_n, hit_s;

  assign elig = thr_ready & ~blk_q;

  always_comb begin
    hit_n = 1'b0;
    hit_s = 1'b0;
    pos_n = '0;
    pos_s = '0;
    for (int k = 0; k < NTHR; k++) begin
      if (elig[ord_q[k]] && !spec_q[ord_q[k]] && !hit_n) begin
        hit_n = 1'b1;
        pos_n = IDW'(k);
      end
      if (elig[ord_q[k]] && spec_q[ord_q[k]] && !hit_s) begin
        hit_s = 1'b1;
        pos_s = IDW'(k);
      end
    end
  end

  assign pick_pos    = hit_n ? pos_n : pos_s;
  assign pick_id     = ord_q[pick_pos];
  assign issue_valid = hit_n | hit_s;
  assign issue_sel   = issue_valid ? (NTHR'(1) << pick_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '1;
      spec_q <= '0;
      for (int k = 0; k < NTHR; k++) ord_q[k] <= IDW'(k);
    end else begin
      blk_q  <= thr_stall | thr_longwait;
      spec_q <= thr_specload;
      if (issue_valid) begin
        for (int k = 0; k < NTHR - 1; k++)
          if (IDW'(k) >= pick_pos) ord_q[k] <= ord_q[k+1];
        ord_q[NTHR-1] <= pick_id;
      end
    end
  end

  logic [NTHR*IDW-1:0] ord_flat;
  logic [NTHR-1:0]     ord_seen;
  always_comb begin
    ord_seen = '0;
    for (int k = 0; k < NTHR; k++) begin
      ord_flat[k*IDW +: IDW] = ord_q[k];
      ord_seen[ord_q[k]]     = 1'b1;
    end
  end

  a_r7_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_sel) && (issue_valid == (issue_sel != '0)));

  a_r2_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_sel & ~thr_ready) == '0);

  a_r2_blocked_next: assert property (@(posedge clk) disable iff (!rst_n)
    |(thr_stall | thr_longwait) |=> (issue_sel & $past(thr_stall | thr_longwait)) == '0);

  a_r4_spec_loses: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !((issue_sel & $past(thr_specload)) != '0 &&
               (thr_ready & ~$past(thr_stall | thr_longwait | thr_specload)) != '0));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(ord_flat));

  a_r5_newest: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> ord_q[NTHR-1] == $past(pick_id));

  a_r9_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    &ord_seen);
endmodule

// File: tb/thread_pick_bench.sv
`timescale 1ns/1ps
module thread_pick_bench;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] rdy = '0, st = '0, lw = '0, sp = '0;
  logic [N-1:0] sel;
  logic vld;
  int checks = 0, fails = 0;
  int ord[$];
  bit blk[N];
  bit spc[N];

  thread_pick #(.NTHR(N)) u_thread_pick (
    .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .thr_stall(st),
    .thr_longwait(lw), .thr_specload(sp), .issue_sel(sel), .issue_valid(vld));

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_pick();
    for (int pass = 0; pass < 2; pass++)
      foreach (ord[k]) begin
        int t = ord[k];
        if (rdy[t] && !blk[t] && (spc[t] == (pass == 1))) return t;
      end
    return -1;
  endfunction

  task automatic step(logic [N-1:0] r, logic [N-1:0] s, logic [N-1:0] l,
                      logic [N-1:0] p, string tag);
    int e;
    logic [N-1:0] es;
    string t;
    @(negedge clk);
    rdy = r; st = s; lw = l; sp = p;
    #1;
    e  = model_pick();
    es = (e < 0) ? '0 : N'(1) << e;
    if (tag != "") t = tag;
    else if (e < 0) t = "R6";
    else if (spc[e]) t = "R4";
    else t = "R3";
    chk(vld === (e >= 0), (e >= 0 && tag == "") ? "R8" : t, "valid", int'(vld), int'(e >= 0));
    chk(sel === es, t, "select", int'(sel), int'(es));
    chk($onehot0(sel) && (vld == (sel != '0)), "R7", "onehot", int'(sel), int'(es));
    if (e >= 0) begin
      foreach (ord[k]) if (ord[k] == e) begin ord.delete(k); break; end
      ord.push_back(e);
    end
    for (int i = 0; i < N; i++) begin
      blk[i] = s[i] | l[i];
      spc[i] = p[i];
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int exp5[5] = '{0, 1, 2, 3, 0};
    ord = {0, 1, 2, 3};
    for (int i = 0; i < N; i++) begin blk[i] = 1; spc[i] = 0; end
    rdy = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(vld === 1'b0 && sel === '0, "R1", "in-reset grant", int'(sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(vld === 1'b0 && sel === '0, "R1", "first cycle grant", int'(sel), 0);
    for (int i = 0; i < N; i++) blk[i] = 0;

    for (int i = 0; i < 5; i++) begin
      step('1, '0, '0, '0, "R5");
      chk(sel === (N'(1) << exp5[i]), "R5", "rotation", int'(sel), 1 << exp5[i]);
    end

    step('1, 4'b0010, '0, '0, "R2");
    step('1, '0, '0, '0, "R2");
    chk(sel[1] === 1'b0, "R2", "stalled thread granted", int'(sel), 0);
    step(4'b1101, '0, '0, '0, "R2");
    chk(sel[1] === 1'b0, "R2", "unready thread granted", int'(sel), 0);

    step('1, '0, 4'b0100, '0, "R9");
    step('1, '0, 4'b0100, '0, "R9");
    step('1, '0, 4'b0100, '0, "R9");
    step('1, '0, '0, '0, "R9");
    step('1, '0, '0, '0, "R9");

    step('1, '0, '0, 4'b1011, "R4");
    step('1, '0, '0, 4'b1011, "R4");
    step('1, '0, '0, 4'b1111, "R4");
    step('1, '0, '0, '0, "R4");

    step('0, '0, '0, '0, "R6");
    step('0, '0, '0, '0, "R6");
    step('1, '1, '0, '0, "R6");
    step('1, '0, '0, '0, "R6");
    step('1, '0, '0, '0, "R6");

    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r, s, l, p;
      for (int i = 0; i < N; i++) begin
        r[i] = ($urandom % 4) != 0;
        s[i] = ($urandom % 7) == 0;
        l[i] = ($urandom % 10) == 0;
        p[i] = ($urandom % 4) == 0;
      end
      step(r, s, l, p, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule